// File: doc/BRIEF.md
# GF(2) Idempotent-Form Linear Solver

This block solves a binary linear system Z·L = U, where L is an M×M matrix over GF(2) and U is an M-bit row vector. After a start pulse it takes a copy of L and U and repeats a three-step pass M times. The first step may exchange two columns to bring a usable pivot into the leftmost column. The second step adds the leftmost column into every other column whose top entry is one. The third step rotates the rows up by one and the columns left by one. Every column operation applied to L is also applied to U. When the passes are finished, L has become upper triangular and idempotent: a zero on the diagonal means that whole column is zero, and a one on the diagonal means the rest of that row is zero.

From this reduced form the block decides whether the system has a solution. If it does, it outputs one particular solution, together with the nonzero rows of the reduced matrix plus the identity, which form a basis of the homogeneous solution space. Every solution is then the particular root plus some XOR combination of the valid basis rows. A root-finding stage that has built a linearized polynomial as a bit matrix uses this block, and enumerating the roots is left to the logic that follows it.

Top module: `tis_solver`

## Requirements
- R1: After synchronous reset, `done`, `found`, `no_solution` and `busy` are low, and `root`, `basis` and `basis_valid` are all zero.
- R2: `done` is a single-cycle pulse. It goes high after the 3M+1-th rising edge that follows the edge accepting `start`: M passes of three single-clock steps, then one clock to register the results. `busy` is high from the accepting edge until `done`.
- R3: A `start` that arrives while `busy` is high is ignored. The running solve keeps its timing and its operands, and no extra `done` follows it.
- R4: While `done` is high, exactly one of `found` and `no_solution` is set. `found` is set exactly when some Z satisfies Z·L = U, meaning U lies in the row space of L.
- R5: When `found` is set, `root` satisfies root·L = U. When `no_solution` is set, `root` is zero.
- R6: When `found` is set, each row k flagged in `basis_valid` has bit k set and satisfies row·L = 0. Rows that are not flagged are zero. The number of flagged rows equals M minus the rank of L.
- R7: When `no_solution` is set, `basis_valid` and `basis` are all zero.
- R8: `root`, `found`, `no_solution`, `basis` and `basis_valid` change only on the edge that raises `done`. They hold their values at all other times.
- R9: Encoding: row i of L is `mat_in[i*M +: M]` and its bit j is column j. The same layout is used for `basis`. Z·L is the XOR of the rows i for which bit i of Z is set. `root` and basis rows are indexed the same way as Z.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a solve. Sampled only when idle. |
| mat_in | input | M*M | Matrix L, row-major, row i at bits i*M |
| vec_in | input | M | Right-hand vector U |
| busy | output | 1 | Solve in progress |
| done | output | 1 | One-cycle pulse when results are written |
| found | output | 1 | The system is consistent |
| no_solution | output | 1 | The system is inconsistent |
| root | output | M | Particular solution Z |
| basis | output | M*M | Homogeneous basis rows, row k at bits k*M |
| basis_valid | output | M | Per-row valid mask for `basis` |

## Verification
Every result appears together with `done`, exactly 3M+1 rising edges after the edge that accepted `start`. With the default M = 8, that is 25 edges. The bench counts edges from the accepting edge and samples at the following falling edge, then checks that `done` first appears on count 3M+1. Only after that does it compare the registered outputs with an independent Gaussian-elimination rank and substitution check. For the ignored-start case and the hold case, the bench keeps watching for more than 3M+1 further cycles. This confirms that no second `done` appears and that the outputs do not move.

// File: rtl/tis_pkg.sv
package tis_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SWAP,
    ST_CLR,
    ST_ROT,
    ST_FIN
  } tis_state_e;
endpackage

// File: rtl/tis_pivot_pick.sv
module tis_pivot_pick #(
  parameter int M  = 8,
  parameter int IW = 3
) (
  input  logic [M-1:0]  top_row,
  input  logic [M-1:0]  diag,
  output logic          swap_en,
  output logic [IW-1:0] swap_idx
);
  logic [M-1:0] cand_zero_diag;
  logic [M-1:0] cand_one_diag;

  always_comb begin
    cand_zero_diag    = top_row & ~diag;
    cand_one_diag     = top_row & diag;
    cand_zero_diag[0] = 1'b0;
    cand_one_diag[0]  = 1'b0;
    swap_en  = 1'b0;
    swap_idx = '0;
    if (!top_row[0]) begin
      // fallback: leftmost column with a one on its diagonal
      for (int j = M - 1; j >= 1; j--) begin
        if (cand_one_diag[j]) begin
          swap_en  = 1'b1;
          swap_idx = IW'(j);
        end
      end
      // preferred: leftmost column with a zero on its diagonal (overrides)
      for (int j = M - 1; j >= 1; j--) begin
        if (cand_zero_diag[j]) begin
          swap_en  = 1'b1;
          swap_idx = IW'(j);
        end
      end
    end
  end
endmodule

// File: rtl/tis_root_check.sv
module tis_root_check #(
  parameter int M = 8
) (
  input  logic [M-1:0][M-1:0] red_mat,
  input  logic [M-1:0]        red_vec,
  output logic                sol_ok,
  output logic [M-1:0]        sol_root,
  output logic [M-1:0][M-1:0] sol_basis,
  output logic [M-1:0]        sol_valid
);
  logic [M-1:0] diag;

  for (genvar k = 0; k < M; k++) begin : g_diag
    assign diag[k] = red_mat[k][k];
  end

  // the vector is a root when it has no bit where the diagonal is zero
  assign sol_ok   = ~|(red_vec & ~diag);
  assign sol_root = sol_ok ? red_vec : '0;

  for (genvar k = 0; k < M; k++) begin : g_basis
    localparam logic [M-1:0] UNIT = M'(1) << k;
    assign sol_valid[k] = sol_ok & ~diag[k];
    assign sol_basis[k] = sol_valid[k] ? (red_mat[k] ^ UNIT) : '0;
  end
endmodule

// File: rtl/tis_solver.sv
module tis_solver #(
  parameter int M = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [M*M-1:0] mat_in,
  input  logic [M-1:0]   vec_in,
  output logic           busy,
  output logic           done,
  output logic           found,
  output logic           no_solution,
  output logic [M-1:0]   root,
  output logic [M*M-1:0] basis,
  output logic [M-1:0]   basis_valid
);
  import tis_pkg::*;

  localparam int IW  = (M > 1) ? $clog2(M) : 1;
  localparam int LAT = 3 * M + 1;
  localparam int CW  = $clog2(LAT + 2);

  tis_state_e          state;
  logic [IW-1:0]       iter;
  logic [M-1:0][M-1:0] mat_q;
  logic [M-1:0]        vec_q;
  logic [M-1:0][M-1:0] mat_nxt;
  logic [M-1:0]        vec_nxt;
  logic [M-1:0]        diag;
  logic                sw_en;
  logic [IW-1:0]       sw_idx;
  logic                rc_ok;
  logic [M-1:0]        rc_root;
  logic [M-1:0][M-1:0] rc_basis;
  logic [M-1:0]        rc_valid;
  logic                accept;

  assign accept = (state == ST_IDLE) && start;
  assign busy   = (state != ST_IDLE);

  for (genvar k = 0; k < M; k++) begin : g_diag
    assign diag[k] = mat_q[k][k];
  end

  tis_pivot_pick #(.M(M), .IW(IW)) u_pick (
    .top_row (mat_q[0]),
    .diag    (diag),
    .swap_en (sw_en),
    .swap_idx(sw_idx)
  );

  tis_root_check #(.M(M)) u_chk (
    .red_mat  (mat_q),
    .red_vec  (vec_q),
    .sol_ok   (rc_ok),
    .sol_root (rc_root),
    .sol_basis(rc_basis),
    .sol_valid(rc_valid)
  );

  // one reduction step per clock; U is treated as an extra row
  always_comb begin
    mat_nxt = mat_q;
    vec_nxt = vec_q;
    case (state)
      ST_SWAP: begin
        if (sw_en) begin
          for (int r = 0; r < M; r++) begin
            mat_nxt[r][0]      = mat_q[r][sw_idx];
            mat_nxt[r][sw_idx] = mat_q[r][0];
          end
          vec_nxt[0]      = vec_q[sw_idx];
          vec_nxt[sw_idx] = vec_q[0];
        end
      end
      ST_CLR: begin
        for (int j = 1; j < M; j++) begin
          if (mat_q[0][j]) begin
            for (int r = 0; r < M; r++) begin
              mat_nxt[r][j] = mat_q[r][j] ^ mat_q[r][0];
            end
            vec_nxt[j] = vec_q[j] ^ vec_q[0];
          end
        end
      end
      ST_ROT: begin
        for (int r = 0; r < M; r++) begin
          mat_nxt[r] = {mat_q[(r + 1) % M][0], mat_q[(r + 1) % M][M-1:1]};
        end
        vec_nxt = {vec_q[0], vec_q[M-1:1]};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      iter        <= '0;
      mat_q       <= '0;
      vec_q       <= '0;
      done        <= 1'b0;
      found       <= 1'b0;
      no_solution <= 1'b0;
      root        <= '0;
      basis       <= '0;
      basis_valid <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            mat_q <= mat_in;
            vec_q <= vec_in;
            iter  <= '0;
            state <= ST_SWAP;
          end
        end
        ST_SWAP: begin
          mat_q <= mat_nxt;
          vec_q <= vec_nxt;
          state <= ST_CLR;
        end
        ST_CLR: begin
          mat_q <= mat_nxt;
          vec_q <= vec_nxt;
          state <= ST_ROT;
        end
        ST_ROT: begin
          mat_q <= mat_nxt;
          vec_q <= vec_nxt;
          if (iter == IW'(M - 1)) begin
            state <= ST_FIN;
          end else begin
            iter  <= iter + 1'b1;
            state <= ST_SWAP;
          end
        end
        ST_FIN: begin
          done        <= 1'b1;
          found       <= rc_ok;
          no_solution <= ~rc_ok;
          root        <= rc_root;
          basis       <= rc_basis;
          basis_valid <= rc_valid;
          state       <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  logic [CW-1:0] lat_cnt;
  always_ff @(posedge clk) begin
    if (rst)         lat_cnt <= '0;
    else if (accept) lat_cnt <= '0;
    else if (busy)   lat_cnt <= lat_cnt + 1'b1;
  end

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat_cnt == CW'(LAT)));

  p_one_flag_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> (found != no_solution));

  p_nosol_mask_r7: assert property (@(posedge clk) disable iff (rst)
    no_solution |-> (basis_valid == '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (state != ST_FIN) |=> ($stable(root) && $stable(found) && $stable(basis_valid)));

  p_pivot_top_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SWAP && sw_en) |-> mat_q[0][sw_idx]);

  p_top_cleared_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ROT) |-> $onehot0(mat_q[0]));
endmodule

// File: tb/tb_tis_solver.sv
module tb_tis_solver;
  localparam int M   = 8;
  localparam int LAT = 3 * M + 1;

  logic           clk = 1'b0;
  logic           rst;
  logic           start;
  logic [M*M-1:0] mat_in;
  logic [M-1:0]   vec_in;
  logic           busy, done, found, no_solution;
  logic [M-1:0]   root;
  logic [M*M-1:0] basis;
  logic [M-1:0]   basis_valid;

  int checks = 0;
  int errors = 0;
  logic [31:0] lfsr = 32'h1ACE_5EED;

  always #2 clk = ~clk;

  tis_solver #(.M(M)) dut (
    .clk(clk), .rst(rst), .start(start), .mat_in(mat_in), .vec_in(vec_in),
    .busy(busy), .done(done), .found(found), .no_solution(no_solution),
    .root(root), .basis(basis), .basis_valid(basis_valid)
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [M-1:0] vmul(input logic [M-1:0] z, input logic [M*M-1:0] m);
    logic [M-1:0] acc = '0;
    for (int i = 0; i < M; i++) if (z[i]) acc ^= m[i*M +: M];
    return acc;
  endfunction

  function automatic int rank_rows(input logic [M*M-1:0] m, input logic [M-1:0] extra, input bit use_extra);
    logic [M-1:0] rows [M+1];
    logic [M-1:0] t;
    int n = use_extra ? M + 1 : M;
    int r = 0;
    for (int i = 0; i < M; i++) rows[i] = m[i*M +: M];
    rows[M] = extra;
    for (int c = 0; c < M; c++) begin
      int p = -1;
      for (int i = r; i < n; i++) if (p < 0 && rows[i][c]) p = i;
      if (p >= 0) begin
        t = rows[p]; rows[p] = rows[r]; rows[r] = t;
        for (int i = 0; i < n; i++) if (i != r && rows[i][c]) rows[i] ^= rows[r];
        r++;
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] rnd();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr ^ (lfsr >> 7) ^ (lfsr << 11);
  endfunction

  // pulse start and wait for done; checks R2 latency and busy
  task automatic run(input logic [M*M-1:0] m, input logic [M-1:0] u, input bit extra_start);
    int k;
    bit seen = 0;
    @(negedge clk);
    mat_in = m; vec_in = u; start = 1'b1;
    for (k = 0; k < 4 * M + 10 && !seen; k++) begin
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      if (extra_start && k == 4) begin
        mat_in = ~m; vec_in = ~u; start = 1'b1;   // R3: must be ignored
      end
      if (k == 0) chk(busy == 1'b1, "R2 busy after accept", 64'(busy), 64'd1);
      if (done) begin
        seen = 1;
        chk(k == LAT, "R2 done latency", 64'(k), 64'(LAT));
      end
    end
    start = 1'b0;
    if (!seen) chk(1'b0, "R2 watchdog: done never seen", 64'(k), 64'(LAT));
    mat_in = m; vec_in = u;
  endtask

  task automatic check_out(input logic [M*M-1:0] m, input logic [M-1:0] u, input string tag);
    int rk  = rank_rows(m, u, 0);
    int rka = rank_rows(m, u, 1);
    bit exp_found = (rk == rka);
    chk(found == exp_found, {"R4 found ", tag}, 64'(found), 64'(exp_found));
    chk(no_solution == !exp_found, {"R4 no_solution ", tag}, 64'(no_solution), 64'(!exp_found));
    if (exp_found) begin
      chk(vmul(root, m) == u, {"R5 root*L ", tag}, 64'(vmul(root, m)), 64'(u));
      chk($countones(basis_valid) == M - rk, {"R6 basis count ", tag},
          64'($countones(basis_valid)), 64'(M - rk));
      for (int k = 0; k < M; k++) begin
        logic [M-1:0] row = basis[k*M +: M];
        if (basis_valid[k])
          chk(row[k] && vmul(row, m) == '0, {"R6 basis row in kernel ", tag}, 64'(row), 64'(k));
        else
          chk(row == '0, {"R6 unflagged row zero ", tag}, 64'(row), 64'd0);
      end
    end else begin
      chk(root == '0, {"R5 root zero ", tag}, 64'(root), 64'd0);
      chk(basis_valid == '0 && basis == '0, {"R7 masks zero ", tag}, 64'(basis_valid), 64'd0);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!done && !found && !no_solution && !busy, "R1 flags after reset",
        64'({done, found, no_solution, busy}), 64'd0);
    chk(root == '0 && basis == '0 && basis_valid == '0, "R1 outputs zero after reset", 64'(root), 64'd0);
  endtask

  task automatic t_identity();
    logic [M*M-1:0] m = '0;
    for (int i = 0; i < M; i++) m[i*M + i] = 1'b1;
    run(m, 8'hA5, 0);
    check_out(m, 8'hA5, "identity");
    chk(root == 8'hA5, "R5 identity root equals U", 64'(root), 64'hA5);
  endtask

  task automatic t_permutation();
    logic [M*M-1:0] m = '0;
    for (int i = 0; i < M; i++) m[i*M + ((i + 1) % M)] = 1'b1;
    run(m, 8'h08, 0);
    check_out(m, 8'h08, "perm");
    chk(root == 8'h04, "R9 row 2 holds column 3", 64'(root), 64'h04);
  endtask

  task automatic t_zero_matrix();
    run('0, '0, 0);
    check_out('0, '0, "zero hom");
    chk(basis_valid == '1, "R6 zero matrix full kernel", 64'(basis_valid), 64'hFF);
    for (int k = 0; k < M; k++)
      chk(basis[k*M +: M] == (M'(1) << k), "R6 zero matrix unit rows", 64'(basis[k*M +: M]), 64'(M'(1) << k));
    run('0, 8'h10, 0);
    check_out('0, 8'h10, "zero inconsistent");
  endtask

  task automatic t_random(input int n, input bit singular, input bit consistent);
    for (int t = 0; t < n; t++) begin
      logic [M*M-1:0] m;
      logic [M-1:0] u;
      for (int i = 0; i < M; i++) m[i*M +: M] = rnd()[M-1:0];
      if (singular) begin
        m[5*M +: M] = m[1*M +: M] ^ m[2*M +: M];
        m[6*M +: M] = m[3*M +: M];
        m[7*M +: M] = '0;
      end
      u = consistent ? vmul(rnd()[M-1:0], m) : rnd()[M-1:0];
      run(m, u, 0);
      check_out(m, u, singular ? "random singular" : "random");
    end
  endtask

  task automatic t_busy_and_hold();
    logic [M*M-1:0] m;
    logic [M-1:0] u, r0, v0;
    logic f0;
    for (int i = 0; i < M; i++) m[i*M +: M] = rnd()[M-1:0];
    m[4*M +: M] = m[0*M +: M];
    u = vmul(8'h3C, m);
    run(m, u, 1);
    check_out(m, u, "R3 ignored start");
    r0 = root; v0 = basis_valid; f0 = found;
    for (int k = 0; k < LAT + 6; k++) begin
      @(negedge clk);
      chk(!done, "R3 no extra done", 64'(done), 64'd0);
      chk(root == r0 && basis_valid == v0 && found == f0, "R8 outputs held", 64'(root), 64'(r0));
    end
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; mat_in = '0; vec_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_identity();
    t_permutation();
    t_zero_matrix();
    t_random(6, 0, 0);
    t_random(6, 1, 1);
    t_random(6, 1, 0);
    t_busy_and_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule